// File: doc/BRIEF.md
# DRAM refresh and init sequencer

This block keeps a fast-page-mode DRAM array alive without help from the access controller. After reset it holds the array idle for a power-up pause. It then runs a fixed number of warm-up refresh cycles and raises `init_done`. From then on an interval timer marks one refresh as due at a fixed spacing, so that every row is covered within the retention period.

Each refresh is a CAS-before-RAS cycle, and the array supplies the row address from its own internal counter. The sequencer asks the access controller for the shared strobes with `arb_req` and waits for `grant`. It then drives all CAS lanes low, drops RAS, releases CAS after the hold time, raises RAS, and waits out the precharge. `busy` is high while it owns the strobes. When the controller is slow to grant, the due refreshes are counted up to a fixed budget. A due refresh that arrives with the budget already full sets a sticky error.

All delays are clock-cycle parameters. The defaults assume a 100 MHz clock: a 200 µs pause, a 15.6 µs interval, a 10 ns CAS lead, 60 ns RAS low, 10 ns CAS hold and 40 ns precharge.

Top module: `dram_rfsh_seq`

## Requirements
- R1: For PAUSE_CYC cycles after reset is released, `arb_req` and `busy` stay low, `ras_n` and every `cas_n` lane stay high, and `grant` has no effect.
- R2: After the pause, exactly WARMUP_CNT refresh cycles (8 by default) run. `init_done` rises in the cycle after the precharge of the last of them ends, and it then stays high until reset.
- R3: `arb_req` rises in the cycle after the block is idle with work outstanding, and it stays high until `grant` is sampled high. A `grant` sampled while `arb_req` is low is ignored.
- R4: A refresh cycle starts on the clock edge that samples `grant` high together with `arb_req`. All `cas_n` lanes then go low for LEAD_CYC cycles while `ras_n` is still high, before `ras_n` falls.
- R5: `ras_n` stays low for exactly RAS_CYC consecutive cycles. The `cas_n` lanes stay low for the first HOLD_CYC of those cycles and then return high.
- R6: After `ras_n` rises, all strobes stay high for PRE_CYC cycles. `busy` is high from the first CAS-low cycle to the last precharge cycle and is low at all other times.
- R7: `we_n` is high at all times.
- R8: Once `init_done` is high, a refresh becomes due every INTERVAL_CYC cycles, the first one INTERVAL_CYC cycles after `init_done` rises. Each due refresh adds one to the pending count, and each grant after initialisation takes one away.
- R9: The pending count saturates at PEND_MAX. A due refresh that arrives with PEND_MAX pending and no grant on the same edge sets `overflow_err`, which stays set until reset.
- R10: All CAS_LANES bits of `cas_n` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Access controller hands over the strobes (sampled with `arb_req`) |
| arb_req | output | 1 | Request for the shared strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes for every byte lane, active low |
| we_n | output | 1 | Write enable, held high |
| busy | output | 1 | Sequencer owns the strobes |
| init_done | output | 1 | Pause and warm-up refreshes complete |
| overflow_err | output | 1 | Sticky: refresh budget exceeded |

## Verification
The properties accept `grant` at any level and in any cycle. They assume only that reset is applied at start-up, and they depend on `grant` solely through the request handshake. The stimulus drives `grant` half a cycle after each edge and uses three regimes. In the first, it grants after a fixed delay while also pulsing `grant` when no request is up. In the second, it grants in the same cycle as the request. In the third, it withholds `grant` long enough to overrun the pending budget. A cycle-accurate behavioural model checks every output in every cycle, and the model never produces timing that the assertions would reject.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        PH_PAUSE,
        PH_IDLE,
        PH_REQ,
        PH_LEAD,
        PH_RASLO,
        PH_PRECH
    } phase_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic due
);
    localparam int unsigned CW = $clog2(INTERVAL_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        due = 1'b0;
        if (!en) begin
            s_d.cnt = RELOAD;
        end else if (s_q.cnt == '0) begin
            due     = 1'b1;
            s_d.cnt = RELOAD;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.cnt <= RELOAD;
        else        s_q     <= s_d;
    end
endmodule

// File: rtl/dram_rfsh_budget.sv
module dram_rfsh_budget #(
    parameter int unsigned PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic due,
    input  logic take,
    output logic pend_nz,
    output logic overflow
);
    localparam int unsigned PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

    typedef struct packed {
        logic [PW-1:0] pend;
        logic          err;
    } bud_s;

    bud_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case ({due, take})
            2'b10: begin
                if (s_q.pend == FULL) s_d.err  = 1'b1;
                else                  s_d.pend = s_q.pend + 1'b1;
            end
            2'b01: begin
                if (s_q.pend != '0) s_d.pend = s_q.pend - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pend <= '0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_nz  = (s_q.pend != '0);
    assign overflow = s_q.err;
endmodule

// File: rtl/dram_rfsh_fsm.sv
module dram_rfsh_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC  = 20000,
    parameter int unsigned WARMUP_CNT = 8,
    parameter int unsigned LEAD_CYC   = 1,
    parameter int unsigned RAS_CYC    = 6,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned PRE_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic pend_nz,
    output logic arb_req,
    output logic take,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic init_done
);
    localparam int unsigned TMAX = max4(PAUSE_CYC, LEAD_CYC, RAS_CYC, PRE_CYC);
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned WW   = $clog2(WARMUP_CNT + 1);
    localparam logic [TW-1:0] HOLD_TH = TW'(RAS_CYC - HOLD_CYC);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] tmr;
        logic [WW-1:0] warm;
        logic          done;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        case (s_q.ph)
            PH_PAUSE: begin
                if (s_q.tmr == '0) s_d.ph  = PH_IDLE;
                else               s_d.tmr = s_q.tmr - 1'b1;
            end
            PH_IDLE: begin
                if (s_q.warm != '0 || pend_nz) s_d.ph = PH_REQ;
            end
            PH_REQ: begin
                if (grant) begin
                    s_d.ph  = PH_LEAD;
                    s_d.tmr = TW'(LEAD_CYC - 1);
                    if (s_q.warm != '0) s_d.warm = s_q.warm - 1'b1;
                    else                take     = 1'b1;
                end
            end
            PH_LEAD: begin
                if (s_q.tmr == '0) begin
                    s_d.ph  = PH_RASLO;
                    s_d.tmr = TW'(RAS_CYC - 1);
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            PH_RASLO: begin
                if (s_q.tmr == '0) begin
                    s_d.ph  = PH_PRECH;
                    s_d.tmr = TW'(PRE_CYC - 1);
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            PH_PRECH: begin
                if (s_q.tmr == '0) begin
                    s_d.ph = PH_IDLE;
                    if (s_q.warm == '0) s_d.done = 1'b1;
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_PAUSE;
            s_q.tmr  <= TW'(PAUSE_CYC - 1);
            s_q.warm <= WW'(WARMUP_CNT);
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign arb_req   = (s_q.ph == PH_REQ);
    assign busy      = (s_q.ph == PH_LEAD) || (s_q.ph == PH_RASLO) || (s_q.ph == PH_PRECH);
    assign ras_n     = (s_q.ph != PH_RASLO);
    assign cas_n     = !((s_q.ph == PH_LEAD) || ((s_q.ph == PH_RASLO) && (s_q.tmr >= HOLD_TH)));
    assign init_done = s_q.done;
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
    parameter int unsigned PAUSE_CYC    = 20000,
    parameter int unsigned WARMUP_CNT   = 8,
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned PEND_MAX     = 8,
    parameter int unsigned LEAD_CYC     = 1,
    parameter int unsigned RAS_CYC      = 6,
    parameter int unsigned HOLD_CYC     = 1,
    parameter int unsigned PRE_CYC      = 4,
    parameter int unsigned CAS_LANES    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant,
    output logic                 arb_req,
    output logic                 ras_n,
    output logic [CAS_LANES-1:0] cas_n,
    output logic                 we_n,
    output logic                 busy,
    output logic                 init_done,
    output logic                 overflow_err
);
    logic due, take, pend_nz, cas_one;

    dram_rfsh_timer #(.INTERVAL_CYC(INTERVAL_CYC)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .due   (due)
    );

    dram_rfsh_budget #(.PEND_MAX(PEND_MAX)) budget_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .due      (due),
        .take     (take),
        .pend_nz  (pend_nz),
        .overflow (overflow_err)
    );

    dram_rfsh_fsm #(
        .PAUSE_CYC  (PAUSE_CYC),
        .WARMUP_CNT (WARMUP_CNT),
        .LEAD_CYC   (LEAD_CYC),
        .RAS_CYC    (RAS_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .PRE_CYC    (PRE_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .pend_nz   (pend_nz),
        .arb_req   (arb_req),
        .take      (take),
        .ras_n     (ras_n),
        .cas_n     (cas_one),
        .busy      (busy),
        .init_done (init_done)
    );

    for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
        assign cas_n[g] = cas_one;
    end

    assign we_n = 1'b1;
endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk #(
    parameter int unsigned RAS_CYC   = 6,
    parameter int unsigned CAS_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 grant,
    input logic                 arb_req,
    input logic                 ras_n,
    input logic [CAS_LANES-1:0] cas_n,
    input logic                 busy,
    input logic                 init_done,
    input logic                 overflow_err
);
    int unsigned ras_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ras_run <= 0;
        else if (!ras_n) ras_run <= ras_run + 1;
        else            ras_run <= 0;
    end

    AST_PRE_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !busy) |-> (ras_n && cas_n == '1)); // R1
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !grant) |=> arb_req); // R3
    AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arb_req); // R3
    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == '0)); // R4
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_run == RAS_CYC)); // R5
    AST_RAS_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> busy); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err); // R9
    AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0) || (cas_n == '1)); // R10
endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(.RAS_CYC(RAS_CYC), .CAS_LANES(CAS_LANES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (grant),
    .arb_req      (arb_req),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .busy         (busy),
    .init_done    (init_done),
    .overflow_err (overflow_err)
);

// File: tb/dram_rfsh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_seq_tb_top;
    localparam int PAUSE = 100;
    localparam int WARM  = 8;
    localparam int INTV  = 40;
    localparam int PMAX  = 8;
    localparam int LEAD  = 1;
    localparam int RASW  = 6;
    localparam int HOLD  = 1;
    localparam int PRE   = 4;
    localparam int SLOT  = LEAD + RASW + PRE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grant = 1'b0;
    logic       arb_req, ras_n, we_n, busy, init_done, overflow_err;
    logic [3:0] cas_n;

    int n_chk = 0, n_fail = 0;
    int mode = 1;
    int wcnt = 0;
    int cyc = 0;
    int warm_falls = 0;
    logic prev_ras = 1'b1;
    bit finished = 0;

    // behavioural reference state
    int m_pause, m_warm, m_pend, m_k, m_tmr;
    bit m_err, m_done, m_req;
    int o_pend;
    bit o_done, due_now, take_now;

    always #2.5 clk = ~clk;

    dram_rfsh_seq #(
        .PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .INTERVAL_CYC(INTV), .PEND_MAX(PMAX),
        .LEAD_CYC(LEAD), .RAS_CYC(RASW), .HOLD_CYC(HOLD), .PRE_CYC(PRE), .CAS_LANES(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .grant(grant), .arb_req(arb_req), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .busy(busy), .init_done(init_done),
        .overflow_err(overflow_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle=%0d act=%0h exp=%0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pause = PAUSE; m_warm = WARM; m_pend = 0; m_k = -1; m_tmr = 0;
            m_err = 0; m_done = 0; m_req = 0;
        end else begin
            o_pend   = m_pend;
            o_done   = m_done;
            due_now  = o_done && (m_tmr == INTV - 1);
            take_now = m_req && grant && (m_warm == 0);
            if (due_now && !take_now) begin
                if (m_pend == PMAX) m_err = 1;
                else                m_pend = m_pend + 1;
            end else if (take_now && !due_now) begin
                m_pend = m_pend - 1;
            end
            m_tmr = o_done ? (m_tmr + 1) % INTV : 0;
            if (m_pause > 0) begin
                m_pause = m_pause - 1;
            end else if (m_req) begin
                if (grant) begin
                    m_req = 0; m_k = 0;
                    if (m_warm > 0) m_warm = m_warm - 1;
                end
            end else if (m_k >= 0) begin
                if (m_k == SLOT - 1) begin
                    m_k = -1;
                    if (m_warm == 0) m_done = 1;
                end else begin
                    m_k = m_k + 1;
                end
            end else if (m_warm > 0 || o_pend > 0) begin
                m_req = 1;
            end
        end
    end

    // compare every cycle, then drive grant for the cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit       e_cas_lo, e_ras_lo, e_busy;
            string    t;
            cyc++;
            e_busy   = (m_k >= 0);
            e_cas_lo = (m_k >= 0) && (m_k < LEAD + HOLD);
            e_ras_lo = (m_k >= LEAD) && (m_k < LEAD + RASW);
            t = (m_pause > 0) ? "R1" : (m_done ? "R8" : "R3");
            chk(arb_req == m_req, t, arb_req, m_req);
            t = (m_pause > 0) ? "R1" : "R5";
            chk(ras_n == !e_ras_lo, t, ras_n, !e_ras_lo);
            t = (m_pause > 0) ? "R1" : "R4";
            chk(cas_n == (e_cas_lo ? 4'h0 : 4'hF), t, cas_n, e_cas_lo ? 4'h0 : 4'hF);
            chk(busy == e_busy, "R6", busy, e_busy);
            chk(init_done == m_done, "R2", init_done, m_done);
            chk(overflow_err == m_err, "R9", overflow_err, m_err);
            chk(we_n == 1'b1, "R7", we_n, 1'b1);
            chk(cas_n == 4'h0 || cas_n == 4'hF, "R10", cas_n, 4'hF);
            if (prev_ras && !ras_n && !init_done) warm_falls++;
            prev_ras = ras_n;
            case (mode)
                0: grant = arb_req;
                2: grant = 1'b0;
                default: begin
                    if (arb_req) begin
                        if (wcnt == 2) begin grant = 1'b1; wcnt = 0; end
                        else begin grant = 1'b0; wcnt++; end
                    end else begin
                        grant = cyc[1]; // stray grant without a request
                    end
                end
            endcase
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(arb_req == 0 && busy == 0 && ras_n == 1 && cas_n == 4'hF, "R1", {arb_req, busy, ras_n, cas_n}, 7'h1F);
        chk(init_done == 0 && overflow_err == 0, "R2", {init_done, overflow_err}, 0);
        grant = 1'b1; // held high through reset release: must be ignored in the pause
        rst_n = 1'b1;
        @(negedge clk);
        mode = 1;
        wait (init_done === 1'b1);
        chk(warm_falls == WARM, "R2", warm_falls, WARM);
        repeat (30 * INTV / 10) @(negedge clk);
        mode = 0;
        repeat (5 * INTV) @(negedge clk);
        chk(overflow_err == 0, "R9", overflow_err, 0);
        mode = 2;
        repeat (11 * INTV) @(negedge clk);
        chk(overflow_err == 1, "R9", overflow_err, 1);
        mode = 0;
        repeat (15 * INTV) @(negedge clk);
        chk(arb_req == 0 || busy == 0, "R8", {arb_req, busy}, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule